// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies two signed operands on every cycle that carries a valid strobe and adds the product into an accumulator. The accumulator is held as two words: a high word and a low word, each twice the operand width. A mode input, sampled with each operation, selects how the sum is formed.

In saturating mode only the low word accumulates. On a signed overflow the low word is clamped to the most positive or most negative value, and bit 0 of the high word becomes a sticky overflow flag. In wrapping mode the two words together hold one signed sum: the low word carries into the high word, and only the bottom `HIW` bits of the high word carry meaning. Its upper bits are copies of bit `HIW-1`. Software-side access is reduced to a clear input, a shared load bus with separate high and low strobes, and the two accumulator words driven straight onto output ports.

Top module: `mac_sat16`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both accumulator words read zero.
- R2: `acc_clr` zeroes both words, including the sticky flag, on the next edge. It takes priority over loads and over a valid operation in the same cycle.
- R3: `ld_hi` and `ld_lo` copy `ld_data` into the high and low word respectively on the next edge. Both may be asserted together. Any load suppresses the accumulation that would otherwise happen in that cycle, and a word whose strobe is low is left unchanged.
- R4: `op_a` and `op_b` are two's-complement signed. Their product is the exact signed product, sign-extended to the word width before it is added.
- R5: In saturating mode (`sat_en`=1) with no overflow, the low word becomes low + product modulo 2^32, and the high word is unchanged.
- R6: In saturating mode, overflow occurs when the product and the old low word have the same sign bit and the sum's sign bit differs from it. The low word then becomes 0x7FFFFFFF for a non-negative product and 0x80000000 for a negative one.
- R7: A saturating overflow sets bit 0 of the high word. Later saturating operations and idle cycles leave it set; only clear, a high-word load or a wrapping operation can change it.
- R8: In wrapping mode (`sat_en`=0) the low word becomes low + product modulo 2^32. The high word becomes old high + (all ones if the product is negative, else zero) + the unsigned carry out of the low addition, and then bits 31..HIW are replaced by copies of bit HIW-1 (HIW=10).
- R9: Each valid operation shows its result on the outputs one cycle later. Operations on consecutive cycles each build on the previous result.
- R10: On a cycle with no valid, no load and no clear, both words hold, whatever `op_a`, `op_b` and `sat_en` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_clr | input | 1 | Zero both accumulator words |
| ld_hi | input | 1 | Load `ld_data` into the high word |
| ld_lo | input | 1 | Load `ld_data` into the low word |
| ld_data | input | 32 | Load value |
| op_valid | input | 1 | Accumulate `op_a*op_b` this cycle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| sat_en | input | 1 | 1 = saturating mode, 0 = wrapping mode |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |

## Verification
The bench builds the unit with its default values: 16-bit operands, 32-bit words and a 10-bit significant high field. The narrow high field means wrap-around of the full signed sum, and sign extension from bit 9, can be reached with one preload and a single product instead of millions of accumulations. With 16-bit operands, the extreme products (such as -32768 squared, or 32767 times -32768) cross the clamp limits after one loaded starting value. Random back-to-back streams that mix both modes then exercise carries, sticky persistence and the hand-over between modes.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_CLEAR,
    ACT_LOAD,
    ACT_SAT,
    ACT_WRAP
  } mac_act_e;

  // Same-sign inputs whose sum flips sign mean a signed overflow.
  function automatic logic sign_ovf(input logic p_msb, input logic a_msb, input logic s_msb);
    return (p_msb == a_msb) && (s_msb != p_msb);
  endfunction

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic [2*OPW-1:0] prod
);
  logic signed [2*OPW-1:0] sa, sb;

  always_comb begin
    sa   = {{OPW{a[OPW-1]}}, a};
    sb   = {{OPW{b[OPW-1]}}, b};
    prod = sa * sb;
  end
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
  parameter int ACCW = 32
) (
  input  logic [ACCW-1:0] lo,
  input  logic [ACCW-1:0] hi,
  input  logic [ACCW-1:0] prod,
  output logic [ACCW-1:0] lo_n,
  output logic [ACCW-1:0] hi_n,
  output logic            ovf
);
  localparam logic [ACCW-1:0] MAXP = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] MAXN = {1'b1, {(ACCW-1){1'b0}}};

  logic [ACCW-1:0] sum;

  always_comb begin
    sum = lo + prod;
    ovf = mac_pkg::sign_ovf(prod[ACCW-1], lo[ACCW-1], sum[ACCW-1]);
    if (ovf) begin
      lo_n = prod[ACCW-1] ? MAXN : MAXP;
      hi_n = hi | {{(ACCW-1){1'b0}}, 1'b1};
    end else begin
      lo_n = sum;
      hi_n = hi;
    end
  end
endmodule

// File: rtl/mac_addwrap.sv
module mac_addwrap #(
  parameter int ACCW = 32,
  parameter int HIW  = 10
) (
  input  logic [ACCW-1:0] lo,
  input  logic [ACCW-1:0] hi,
  input  logic [ACCW-1:0] prod,
  output logic [ACCW-1:0] lo_n,
  output logic [ACCW-1:0] hi_n,
  output logic            carry
);
  logic [ACCW-1:0] hi_sum;

  always_comb begin
    {carry, lo_n} = {1'b0, lo} + {1'b0, prod};
    hi_sum = hi + {ACCW{prod[ACCW-1]}} + {{(ACCW-1){1'b0}}, carry};
  end

  generate
    if (HIW >= ACCW) begin : g_full
      assign hi_n = hi_sum;
    end else begin : g_sext
      assign hi_n = {{(ACCW-HIW){hi_sum[HIW-1]}}, hi_sum[HIW-1:0]};
    end
  endgenerate
endmodule

// File: rtl/mac_sat16.sv
module mac_sat16 #(
  parameter int OPW = 16,
  parameter int HIW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_clr,
  input  logic                ld_hi,
  input  logic                ld_lo,
  input  logic [2*OPW-1:0]    ld_data,
  input  logic                op_valid,
  input  logic [OPW-1:0]      op_a,
  input  logic [OPW-1:0]      op_b,
  input  logic                sat_en,
  output logic [2*OPW-1:0]    acc_hi,
  output logic [2*OPW-1:0]    acc_lo
);
  import mac_pkg::*;

  localparam int ACCW = 2 * OPW;

  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] sat_lo, sat_hi, wrp_lo, wrp_hi;
  logic [ACCW-1:0] hi_q, lo_q, hi_d, lo_d;
  logic            sat_ovf, wrp_carry;
  mac_act_e        act;

  // named events for the checker
  logic ovf_evt;
  logic carry_evt;

  mac_mul #(.OPW(OPW)) u_mul (
    .a(op_a), .b(op_b), .prod(prod)
  );

  mac_addsat #(.ACCW(ACCW)) u_sat (
    .lo(lo_q), .hi(hi_q), .prod(prod),
    .lo_n(sat_lo), .hi_n(sat_hi), .ovf(sat_ovf)
  );

  mac_addwrap #(.ACCW(ACCW), .HIW(HIW)) u_wrap (
    .lo(lo_q), .hi(hi_q), .prod(prod),
    .lo_n(wrp_lo), .hi_n(wrp_hi), .carry(wrp_carry)
  );

  always_comb begin
    if (acc_clr)             act = ACT_CLEAR;
    else if (ld_hi || ld_lo) act = ACT_LOAD;
    else if (op_valid)       act = sat_en ? ACT_SAT : ACT_WRAP;
    else                     act = ACT_HOLD;
  end

  assign ovf_evt   = (act == ACT_SAT) && sat_ovf;
  assign carry_evt = (act == ACT_WRAP) && wrp_carry;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    unique case (act)
      ACT_CLEAR: begin
        hi_d = '0;
        lo_d = '0;
      end
      ACT_LOAD: begin
        if (ld_hi) hi_d = ld_data;
        if (ld_lo) lo_d = ld_data;
      end
      ACT_SAT: begin
        hi_d = sat_hi;
        lo_d = sat_lo;
      end
      ACT_WRAP: begin
        hi_d = wrp_hi;
        lo_d = wrp_lo;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;
endmodule

// File: rtl/mac_sat16_chk.sv
module mac_sat16_chk #(
  parameter int ACCW = 32,
  parameter int HIW  = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_clr,
  input logic            ld_hi,
  input logic            ld_lo,
  input logic [ACCW-1:0] ld_data,
  input logic            op_valid,
  input logic            sat_en,
  input logic [ACCW-1:0] acc_hi,
  input logic [ACCW-1:0] acc_lo,
  input logic            ovf_evt,
  input logic            carry_evt
);
  logic quiet, acc_only;
  assign quiet    = !acc_clr && !ld_hi && !ld_lo && !op_valid;
  assign acc_only = !acc_clr && !ld_hi && !ld_lo && op_valid;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_hi == '0) && (acc_lo == '0)); // R2

  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !acc_clr) |=> acc_lo == $past(ld_data)); // R3

  AST_SAT_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_only && sat_en && !ovf_evt) |=> acc_hi == $past(acc_hi)); // R5

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (acc_lo == {1'b0, {(ACCW-1){1'b1}}}) || (acc_lo == {1'b1, {(ACCW-1){1'b0}}})); // R6

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> acc_hi[0]); // R7

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hi[0] && !acc_clr && !ld_hi && (!op_valid || sat_en)) |=> acc_hi[0]); // R7

  AST_HI_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_only && !sat_en) |=> (acc_hi[ACCW-1:HIW-1] == '0) || (acc_hi[ACCW-1:HIW-1] == '1)); // R8

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    carry_evt |=> acc_lo != $past(acc_lo) || $past(acc_lo) == '0); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(acc_hi) && $stable(acc_lo)); // R10
endmodule

bind mac_sat16 mac_sat16_chk #(.ACCW(ACCW), .HIW(HIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
  .ld_data(ld_data), .op_valid(op_valid), .sat_en(sat_en),
  .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf_evt(ovf_evt), .carry_evt(carry_evt)
);

// File: tb/test_mac_sat16.sv
module test_mac_sat16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0, op_valid = 1'b0, sat_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [31:0] acc_hi, acc_lo;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic [31:0] m_hi = '0, m_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat16 #(.OPW(16), .HIW(10)) i_mac_sat16 (
    .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_data(ld_data), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .sat_en(sat_en), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  // Behavioural reference: full-width integer arithmetic.
  task automatic model_step();
    longint p, s, tot;
    p = longint'($signed(op_a)) * longint'($signed(op_b));
    if (acc_clr) begin
      m_hi = '0; m_lo = '0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) m_hi = ld_data;
      if (ld_lo) m_lo = ld_data;
    end else if (op_valid && sat_en) begin
      s = longint'($signed(m_lo)) + p;
      if (s > 64'sd2147483647) begin
        m_lo = 32'h7FFF_FFFF; m_hi = m_hi | 32'd1;
      end else if (s < -64'sd2147483648) begin
        m_lo = 32'h8000_0000; m_hi = m_hi | 32'd1;
      end else begin
        m_lo = s[31:0];
      end
    end else if (op_valid) begin
      tot = (longint'($signed(m_hi[9:0])) <<< 32) + longint'(m_lo) + p;
      m_lo = tot[31:0];
      m_hi = {{22{tot[41]}}, tot[41:32]};
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (acc_hi !== m_hi || acc_lo !== m_lo) begin
      n_bad++;
      $display("FAIL %s: hi=%h lo=%h expected hi=%h lo=%h", cur_req, acc_hi, acc_lo, m_hi, m_lo);
    end
  endtask

  // inputs are set at the falling edge; outputs compared at the next falling edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    acc_clr = 0; ld_hi = 0; ld_lo = 0; op_valid = 0;
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic sm);
    idle(); op_valid = 1; op_a = a; op_b = b; sat_en = sm; tick();
  endtask

  task automatic load(input logic h, input logic l, input logic [31:0] d);
    idle(); ld_hi = h; ld_lo = l; ld_data = d; tick();
  endtask

  task automatic clear();
    idle(); acc_clr = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R4: signed products in wrapping mode from zero
    cur_req = "R4";
    op(16'hFFFD, 16'd5, 1'b0);           // -15
    op(16'h8000, 16'h8000, 1'b0);        // +2^30
    op(16'h7FFF, 16'h8000, 1'b0);
    op(16'hFFFF, 16'hFFFF, 1'b0);

    // R2: clear beats load and op
    cur_req = "R2";
    idle(); acc_clr = 1; ld_hi = 1; ld_lo = 1; ld_data = 32'hDEAD_BEEF; op_valid = 1; tick();

    // R5: saturating without overflow
    cur_req = "R5";
    load(1'b1, 1'b0, 32'h0000_0000);
    op(16'd100, 16'd200, 1'b1);
    op(16'hFF00, 16'd300, 1'b1);

    // R6/R7: positive clamp, then sticky persistence
    cur_req = "R6";
    load(1'b0, 1'b1, 32'h7FFF_FFF0);
    op(16'h7FFF, 16'h7FFF, 1'b1);
    cur_req = "R7";
    op(16'hFFFF, 16'd1, 1'b1);
    idle(); tick();
    op(16'd3, 16'd3, 1'b1);
    cur_req = "R6";
    load(1'b1, 1'b1, 32'h8000_0010);
    op(16'h8000, 16'h7FFF, 1'b1);
    op(16'h8000, 16'h0001, 1'b1);        // clamp again at minimum

    // R8: carry into the high word and wrap of the 10-bit field
    cur_req = "R8";
    clear();
    load(1'b0, 1'b1, 32'hFFFF_FFFF);
    op(16'd1, 16'd1, 1'b0);
    load(1'b1, 1'b1, 32'h0000_01FF);
    load(1'b0, 1'b1, 32'hFFFF_FFF0);
    op(16'd16, 16'd16, 1'b0);            // high 0x1FF+1 -> 0x200 -> sign extended
    load(1'b1, 1'b1, 32'h0000_0000);
    op(16'hFFFF, 16'd1, 1'b0);           // borrow into all-ones high
    load(1'b1, 1'b0, 32'h1234_5601);     // stray upper bits ignored
    op(16'd2, 16'd2, 1'b0);

    // R3: load suppresses a same-cycle op; single-word load
    cur_req = "R3";
    idle(); ld_lo = 1; ld_data = 32'h0BAD_F00D; op_valid = 1; op_a = 16'd7; op_b = 16'd7; tick();
    load(1'b1, 1'b0, 32'hCAFE_0001);

    // R10: idle cycles with noisy operand and mode inputs
    cur_req = "R10";
    for (int i = 0; i < 20; i++) begin
      idle(); op_a = 16'($urandom); op_b = 16'($urandom); sat_en = 1'($urandom); tick();
    end

    // R9: back-to-back random stream in both modes
    cur_req = "R9";
    clear();
    for (int i = 0; i < 400; i++) begin
      idle();
      op_valid = 1'b1;
      op_a = 16'($urandom); op_b = 16'($urandom);
      sat_en = (i % 64) < 40;
      if ((i % 97) == 96) begin ld_lo = 1; ld_data = $urandom; end
      if ((i % 151) == 150) acc_clr = 1;
      tick();
    end
    idle(); tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule